// File: doc/BRIEF.md
# Tensor accumulator column allocator

This block hands out column ranges of a 512-column by 128-row accumulator array (32-bit cells) to the waves of one workgroup. A wave asks for a power-of-two number of columns between 32 and 512. The block finds a free region aligned to its own size, records that the wave owns it, and returns the base column one cycle later. The region covers all rows of the array. Each wave may use only its own fixed 32-row slice of those rows, selected by its wave index. A wave must hand its columns back with an explicit release before it may exit. An exit while columns are still held is reported as an error.

Every access to the array passes through the block first. The block checks the wave's column offset against its current allocation. If the access is legal, it turns the wave-relative row and column into a physical address one cycle later. Otherwise it raises a fault and produces no address. Free space is kept as a 16-bit occupancy map in 32-column units. Allocate, release and exit requests share one request port, so at most one is handled per cycle.

Top module: `tca_col_alloc`

## Requirements
- R1: After reset, no wave holds columns and the occupancy map is empty. An access from any wave faults, and a 512-column request is granted at base 0.
- R2: An allocate (req_op_i=0) whose size is not one of 32, 64, 128, 256 or 512 responds with code 2 (bad size) and changes no state.
- R3: A granted region is aligned to its own size and is the lowest-addressed free aligned region of that size.
- R4: A request is answered one cycle later by exactly one cycle of rsp_valid_o. A grant carries code 0 with the base column on rsp_base_o.
- R5: An allocate with a legal size that finds no free aligned region responds with code 1 (no space) and changes no state.
- R6: An allocate from a wave that already holds columns responds with code 3 and leaves its existing region in place.
- R7: A release (req_op_i=1) whose base column differs from the requesting wave's recorded base, or that comes from a wave holding nothing, responds with code 4 and changes no state. A matching release responds with code 0 and frees the region.
- R8: An exit (req_op_i=2) from a wave that still holds columns responds with code 5 and keeps the allocation. An exit from a wave holding nothing responds with code 0. Op code 3 produces no response.
- R9: A legal access gives acc_ok_o one cycle later, with physical row 32*wave+row and physical column base+column.
- R10: An access whose column offset is not below the wave's allocated size, or that comes from a wave with no allocation, raises acc_fault_o one cycle later and leaves acc_ok_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 2 | 0 allocate, 1 release, 2 exit, 3 none |
| req_wave_i | input | 2 | Requesting wave |
| req_size_i | input | 10 | Columns requested (allocate) |
| req_base_i | input | 9 | Base column being released |
| acc_valid_i | input | 1 | Access strobe |
| acc_wave_i | input | 2 | Accessing wave |
| acc_row_i | input | 5 | Row offset inside the wave's slice |
| acc_col_i | input | 9 | Column offset inside the allocation |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_code_o | output | 3 | Response code (0 ok, 1 no space, 2 bad size, 3 double, 4 bad release, 5 exit held) |
| rsp_base_o | output | 9 | Granted base column, 0 otherwise |
| acc_ok_o | output | 1 | Access legal, address valid |
| acc_fault_o | output | 1 | Access fault |
| acc_row_o | output | 7 | Physical row |
| acc_col_o | output | 9 | Physical column |

## Verification
The allocator is exercised with several request sequences. A full-array grant shows that no space is left and tests exit and release while columns are held. A mix of 32, 64 and 256 column requests shows that the lowest aligned free region is chosen and that a small hole is skipped when a larger aligned block is needed. A release followed by a reallocation shows that freed units are reused. Illegal sizes, mismatched release bases and repeated allocates are each followed by a request whose result depends on the map, which shows that nothing changed. Accesses are tried at the last legal column and one past it, and at the first and last rows of different slices, which separates the bound check from the address arithmetic.

// File: rtl/tca_pkg.sv
package tca_pkg;
  typedef enum logic [1:0] {
    OP_ALLOC   = 2'd0,
    OP_RELEASE = 2'd1,
    OP_EXIT    = 2'd2,
    OP_NONE    = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    RSP_OK       = 3'd0,
    RSP_NOSPACE  = 3'd1,
    RSP_BADSIZE  = 3'd2,
    RSP_DOUBLE   = 3'd3,
    RSP_BADREL   = 3'd4,
    RSP_EXITHELD = 3'd5
  } rsp_e;
endpackage

// File: rtl/tca_size_decode.sv
module tca_size_decode #(
  parameter int COL_W    = 9,
  parameter int UNIT_LOG = 5,
  parameter int K_W      = 3
) (
  input  logic [COL_W:0]   size_i,
  output logic             valid_o,
  output logic [K_W-1:0]   k_o
);
  always_comb begin
    k_o = '0;
    for (int b = UNIT_LOG; b <= COL_W; b++)
      if (size_i[b]) k_o = K_W'(b - UNIT_LOG);
  end

  // legal: a single bit set, at or above one unit
  assign valid_o = $onehot(size_i) && (size_i[UNIT_LOG-1:0] == '0);
endmodule

// File: rtl/tca_region_find.sv
module tca_region_find #(
  parameter int NUM_UNITS = 16,
  parameter int UNIT_W    = 4,
  parameter int K_W       = 3
) (
  input  logic [NUM_UNITS-1:0] occ_i,
  input  logic [K_W-1:0]       k_i,
  output logic                 found_o,
  output logic [UNIT_W-1:0]    base_o
);
  localparam int NUM_K = $clog2(NUM_UNITS) + 1;

  logic              fnd_arr  [NUM_K];
  logic [UNIT_W-1:0] base_arr [NUM_K];

  for (genvar g = 0; g < NUM_K; g++) begin : g_span
    localparam int SPAN = 1 << g;
    localparam logic [NUM_UNITS-1:0] SMASK = NUM_UNITS'((64'd1 << SPAN) - 64'd1);
    always_comb begin
      fnd_arr[g]  = 1'b0;
      base_arr[g] = '0;
      // descending scan: the lowest free aligned slot is written last
      for (int i = NUM_UNITS / SPAN - 1; i >= 0; i--) begin
        if (((occ_i >> (i * SPAN)) & SMASK) == '0) begin
          fnd_arr[g]  = 1'b1;
          base_arr[g] = UNIT_W'(i * SPAN);
        end
      end
    end
  end

  always_comb begin
    found_o = 1'b0;
    base_o  = '0;
    for (int k = 0; k < NUM_K; k++) begin
      if (k_i == K_W'(k)) begin
        found_o = fnd_arr[k];
        base_o  = base_arr[k];
      end
    end
  end
endmodule

// File: rtl/tca_access_check.sv
module tca_access_check #(
  parameter int COL_W    = 9,
  parameter int UNIT_W   = 4,
  parameter int UNIT_LOG = 5,
  parameter int K_W      = 3,
  parameter int WAVE_W   = 2,
  parameter int RROW_W   = 5
) (
  input  logic                     held_i,
  input  logic [UNIT_W-1:0]        base_i,
  input  logic [K_W-1:0]           k_i,
  input  logic [WAVE_W-1:0]        wave_i,
  input  logic [RROW_W-1:0]        row_i,
  input  logic [COL_W-1:0]         col_i,
  output logic                     ok_o,
  output logic [WAVE_W+RROW_W-1:0] prow_o,
  output logic [COL_W-1:0]         pcol_o
);
  logic [COL_W:0] limit;

  assign limit  = (COL_W+1)'(1) << (UNIT_LOG + int'(k_i));
  assign ok_o   = held_i && ({1'b0, col_i} < limit);
  assign prow_o = {wave_i, row_i};
  assign pcol_o = (COL_W'(base_i) << UNIT_LOG) + col_i;
endmodule

// File: rtl/tca_col_alloc.sv
module tca_col_alloc
  import tca_pkg::*;
#(
  parameter int NUM_COLS      = 512,
  parameter int NUM_WAVES     = 4,
  parameter int ROWS_PER_WAVE = 32,
  parameter int UNIT_COLS     = 32,
  localparam int COL_W        = $clog2(NUM_COLS),
  localparam int WAVE_W       = $clog2(NUM_WAVES),
  localparam int RROW_W       = $clog2(ROWS_PER_WAVE),
  localparam int ROW_W        = WAVE_W + RROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [WAVE_W-1:0] req_wave_i,
  input  logic [COL_W:0]    req_size_i,
  input  logic [COL_W-1:0]  req_base_i,
  input  logic              acc_valid_i,
  input  logic [WAVE_W-1:0] acc_wave_i,
  input  logic [RROW_W-1:0] acc_row_i,
  input  logic [COL_W-1:0]  acc_col_i,
  output logic              rsp_valid_o,
  output logic [2:0]        rsp_code_o,
  output logic [COL_W-1:0]  rsp_base_o,
  output logic              acc_ok_o,
  output logic              acc_fault_o,
  output logic [ROW_W-1:0]  acc_row_o,
  output logic [COL_W-1:0]  acc_col_o
);
  localparam int NUM_UNITS = NUM_COLS / UNIT_COLS;
  localparam int UNIT_W    = $clog2(NUM_UNITS);
  localparam int UNIT_LOG  = $clog2(UNIT_COLS);
  localparam int K_W       = $clog2($clog2(NUM_UNITS) + 1);

  logic [NUM_UNITS-1:0] occ_q;
  logic [NUM_WAVES-1:0] held_q;
  logic [UNIT_W-1:0]    base_q [NUM_WAVES];
  logic [K_W-1:0]       k_q    [NUM_WAVES];

  logic [2:0]           rsp_code_q;
  logic                 rsp_alloc_q;
  logic [K_W-1:0]       rsp_k_q;

  function automatic logic [NUM_UNITS-1:0] unit_mask(logic [UNIT_W-1:0] b, logic [K_W-1:0] k);
    return NUM_UNITS'(((64'd1 << (64'd1 << k)) - 64'd1) << b);
  endfunction

  // request decode
  logic              size_ok;
  logic [K_W-1:0]    req_k;
  logic              fnd;
  logic [UNIT_W-1:0] fnd_base;

  tca_size_decode #(.COL_W(COL_W), .UNIT_LOG(UNIT_LOG), .K_W(K_W)) u_size (
    .size_i (req_size_i),
    .valid_o(size_ok),
    .k_o    (req_k)
  );

  tca_region_find #(.NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W), .K_W(K_W)) u_find (
    .occ_i  (occ_q),
    .k_i    (req_k),
    .found_o(fnd),
    .base_o (fnd_base)
  );

  op_e  op;
  rsp_e code;
  logic do_grant, do_free, do_rsp;
  logic wave_held;
  logic base_match;

  assign op         = op_e'(req_op_i);
  assign wave_held  = held_q[req_wave_i];
  assign base_match = req_base_i == (COL_W'(base_q[req_wave_i]) << UNIT_LOG);

  always_comb begin
    code     = RSP_OK;
    do_grant = 1'b0;
    do_free  = 1'b0;
    do_rsp   = req_valid_i && (op != OP_NONE);
    unique case (op)
      OP_ALLOC: begin
        if (!size_ok)       code = RSP_BADSIZE;
        else if (wave_held) code = RSP_DOUBLE;
        else if (!fnd)      code = RSP_NOSPACE;
        else                do_grant = req_valid_i;
      end
      OP_RELEASE: begin
        if (!wave_held || !base_match) code = RSP_BADREL;
        else                           do_free = req_valid_i;
      end
      OP_EXIT: if (wave_held) code = RSP_EXITHELD;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q       <= '0;
      held_q      <= '0;
      base_q      <= '{default: '0};
      k_q         <= '{default: '0};
      rsp_valid_o <= 1'b0;
      rsp_code_q  <= '0;
      rsp_base_o  <= '0;
      rsp_alloc_q <= 1'b0;
      rsp_k_q     <= '0;
    end else begin
      rsp_valid_o <= do_rsp;
      rsp_code_q  <= code;
      rsp_alloc_q <= do_grant;
      rsp_k_q     <= req_k;
      rsp_base_o  <= do_grant ? (COL_W'(fnd_base) << UNIT_LOG) : '0;
      if (do_grant) begin
        occ_q              <= occ_q | unit_mask(fnd_base, req_k);
        held_q[req_wave_i] <= 1'b1;
        base_q[req_wave_i] <= fnd_base;
        k_q[req_wave_i]    <= req_k;
      end else if (do_free) begin
        occ_q              <= occ_q & ~unit_mask(base_q[req_wave_i], k_q[req_wave_i]);
        held_q[req_wave_i] <= 1'b0;
      end
    end
  end

  assign rsp_code_o = rsp_code_q;

  // access path
  logic             acc_pass;
  logic [ROW_W-1:0] prow;
  logic [COL_W-1:0] pcol;

  tca_access_check #(
    .COL_W(COL_W), .UNIT_W(UNIT_W), .UNIT_LOG(UNIT_LOG),
    .K_W(K_W), .WAVE_W(WAVE_W), .RROW_W(RROW_W)
  ) u_acc (
    .held_i(held_q[acc_wave_i]),
    .base_i(base_q[acc_wave_i]),
    .k_i   (k_q[acc_wave_i]),
    .wave_i(acc_wave_i),
    .row_i (acc_row_i),
    .col_i (acc_col_i),
    .ok_o  (acc_pass),
    .prow_o(prow),
    .pcol_o(pcol)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_ok_o    <= 1'b0;
      acc_fault_o <= 1'b0;
      acc_row_o   <= '0;
      acc_col_o   <= '0;
    end else begin
      acc_ok_o    <= acc_valid_i && acc_pass;
      acc_fault_o <= acc_valid_i && !acc_pass;
      acc_row_o   <= (acc_valid_i && acc_pass) ? prow : '0;
      acc_col_o   <= (acc_valid_i && acc_pass) ? pcol : '0;
    end
  end

  // R3
  grant_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_alloc_q |->
      ((rsp_base_o & COL_W'((64'd1 << (UNIT_LOG + int'(rsp_k_q))) - 64'd1)) == '0));

  // R2, R5, R6, R7, R8
  reject_keeps_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_code_o != RSP_OK) |-> (occ_q == $past(occ_q)));

  // R4
  grant_grows_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_alloc_q |-> ($countones(occ_q) > $countones($past(occ_q))));

  // R10
  acc_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_ok_o && acc_fault_o));

  // R10
  acc_unheld_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !held_q[acc_wave_i] |=> acc_fault_o);

  // R9
  acc_row_slice_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && held_q[acc_wave_i] && (acc_col_i == '0) |=>
      acc_ok_o && (acc_row_o[ROW_W-1:RROW_W] == $past(acc_wave_i)));
endmodule

// File: tb/tca_col_alloc_tb.sv
module tca_col_alloc_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [1:0] req_op_i = 2'd3;
  logic [1:0] req_wave_i = '0;
  logic [9:0] req_size_i = '0;
  logic [8:0] req_base_i = '0;
  logic       acc_valid_i = 1'b0;
  logic [1:0] acc_wave_i = '0;
  logic [4:0] acc_row_i = '0;
  logic [8:0] acc_col_i = '0;
  logic       rsp_valid_o;
  logic [2:0] rsp_code_o;
  logic [8:0] rsp_base_o;
  logic       acc_ok_o, acc_fault_o;
  logic [6:0] acc_row_o;
  logic [8:0] acc_col_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tca_col_alloc u_dut (.*);

  task automatic check(input bit pass, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!pass) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // issue one request and check the response one cycle later
  task automatic req(input string r, input int op, input int w, input int size,
                     input int base, input int exp_code, input int exp_base);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = 2'(op); req_wave_i = 2'(w);
    req_size_i = 10'(size); req_base_i = 9'(base);
    @(negedge clk_i);
    req_valid_i = 1'b0; req_op_i = 2'd3;
    check(rsp_valid_o == 1'b1, r, "rsp_valid", int'(rsp_valid_o), 1);
    check(int'(rsp_code_o) == exp_code, r, "rsp_code", int'(rsp_code_o), exp_code);
    if (exp_code == 0 && op == 0)
      check(int'(rsp_base_o) == exp_base, r, "rsp_base", int'(rsp_base_o), exp_base);
    @(negedge clk_i);
    check(rsp_valid_o == 1'b0, "R4", "rsp_valid single cycle", int'(rsp_valid_o), 0);
  endtask

  task automatic acc(input string r, input int w, input int row, input int col,
                     input bit exp_ok, input int exp_row, input int exp_col);
    @(negedge clk_i);
    acc_valid_i = 1'b1; acc_wave_i = 2'(w); acc_row_i = 5'(row); acc_col_i = 9'(col);
    @(negedge clk_i);
    acc_valid_i = 1'b0;
    check(acc_ok_o == exp_ok, r, "acc_ok", int'(acc_ok_o), int'(exp_ok));
    check(acc_fault_o == !exp_ok, r, "acc_fault", int'(acc_fault_o), int'(!exp_ok));
    if (exp_ok) begin
      check(int'(acc_row_o) == exp_row, r, "acc_row", int'(acc_row_o), exp_row);
      check(int'(acc_col_o) == exp_col, r, "acc_col", int'(acc_col_o), exp_col);
    end
  endtask

  task automatic t_reset;
    check(rsp_valid_o == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid_o), 0);
    check(acc_ok_o == 1'b0, "R1", "acc_ok after reset", int'(acc_ok_o), 0);
    for (int w = 0; w < 4; w++) acc("R1", w, 0, 0, 1'b0, 0, 0);
  endtask

  task automatic t_bad_size;
    req("R2", 0, 0, 0, 0, 2, 0);
    req("R2", 0, 0, 16, 0, 2, 0);
    req("R2", 0, 0, 48, 0, 2, 0);
    req("R2", 0, 1, 96, 0, 2, 0);
    req("R2", 0, 1, 1023, 0, 2, 0);
    // op 3 gives no response
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = 2'd3;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(rsp_valid_o == 1'b0, "R8", "op 3 response", int'(rsp_valid_o), 0);
  endtask

  task automatic t_full;
    req("R1", 0, 0, 512, 0, 0, 0);          // map empty after bad sizes
    req("R5", 0, 1, 32, 0, 1, 0);
    req("R7", 1, 0, 0, 32, 4, 0);           // wrong base
    req("R7", 1, 1, 0, 0, 4, 0);            // wave holds nothing
    req("R8", 2, 0, 0, 0, 5, 0);            // exit while holding
    acc("R9", 0, 5, 511, 1'b1, 5, 511);     // allocation kept
    req("R6", 0, 0, 32, 0, 3, 0);
    acc("R6", 0, 0, 300, 1'b1, 0, 300);     // 512 region still in place
    req("R7", 1, 0, 0, 0, 0, 0);
    req("R8", 2, 0, 0, 0, 0, 0);
    acc("R10", 0, 0, 0, 1'b0, 0, 0);
  endtask

  task automatic t_first_fit;
    req("R3", 0, 0, 32, 0, 0, 0);
    req("R3", 0, 1, 64, 0, 0, 64);          // skips unit 1 hole
    req("R3", 0, 2, 32, 0, 0, 32);          // fills the hole
    req("R3", 0, 3, 256, 0, 0, 256);        // needs 8-unit alignment
    req("R5", 0, 0, 0, 0, 2, 0);
    acc("R9", 1, 31, 63, 1'b1, 63, 127);
    acc("R10", 1, 31, 64, 1'b0, 0, 0);
    acc("R9", 3, 0, 255, 1'b1, 96, 511);
    acc("R9", 3, 7, 0, 1'b1, 103, 256);
    acc("R10", 2, 0, 32, 1'b0, 0, 0);
    acc("R9", 2, 1, 31, 1'b1, 65, 63);
  endtask

  task automatic t_reuse;
    req("R7", 1, 1, 0, 64, 0, 0);
    acc("R10", 1, 0, 0, 1'b0, 0, 0);
    req("R7", 1, 2, 0, 32, 0, 0);
    req("R7", 1, 0, 0, 0, 0, 0);
    req("R5", 0, 1, 512, 0, 1, 0);          // wave 3 still at 256
    req("R3", 0, 0, 128, 0, 0, 0);          // freed units reused
    req("R3", 0, 1, 64, 0, 0, 128);
    acc("R9", 0, 2, 127, 1'b1, 2, 127);
    acc("R10", 0, 2, 128, 1'b0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_bad_size();
    t_full();
    t_first_fit();
    t_reuse();
    repeat (2) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule